// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a circular list of transmit descriptors kept in system memory and turns each described buffer into a byte stream for a MAC transmitter. Every descriptor is 8 bytes. Its first 32-bit word holds a 16-bit length in bits 15:0 and a 16-bit status field in bits 31:16. Its second word holds the byte address of the buffer. Software hands a descriptor to the engine by setting the ready flag. The engine reads the buffer one 32-bit word at a time, presents its bytes on a valid/ready byte port, and then writes the first descriptor word back with the ready flag cleared. This returns the descriptor to software.

The engine is halted after reset. It starts only when software pulses the clear-halt command. It halts on its own when it meets a descriptor that software does not own. A clear-halt pulse later makes it fetch that same descriptor again. A graceful stop request lets the frame in progress finish, then parks the engine and reports completion with a one-cycle event.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset `eng_halted` is 1, and `tx_valid` and `mem_req_valid` are 0. The first `cmd_clear_halt` after reset makes the first memory read go to `cfg_ring_base`.
- R2: The engine reads descriptor word 0 at the ring pointer, then word 1 at the pointer plus 4. Status bit 15 (word 0 bit 31) is the ready flag. If it is 0, the engine halts without reading word 1.
- R3: The engine emits exactly `length` bytes, in ascending address order, starting at the buffer address. The buffer address may have any byte alignment. The byte at address a is taken from memory word lanes 8*(a mod 4)+7 : 8*(a mod 4).
- R4: `tx_last` is 1 only on the final byte of a descriptor whose last-buffer flag (status bit 11) is set. `tx_fcs` equals the append-FCS flag (status bit 10) on every byte of that descriptor.
- R5: After the final byte is accepted, word 0 of the descriptor is written back. In the written word the ready flag is 0, and the length and all other status bits are unchanged unless R10 applies.
- R6: After a writeback the ring pointer moves forward by 8. If the descriptor's wrap flag (status bit 13) was set, the pointer returns to `cfg_ring_base` instead.
- R7: While halted, the engine issues no memory request and no byte. After `cmd_clear_halt`, the next read fetches the same descriptor that caused the halt.
- R8: `cmd_stop_req` takes effect only at a descriptor boundary where no frame is open. A frame is open after a writeback whose last-buffer flag was 0. The engine then halts with `evt_stop_done` high for one cycle, and it does not fetch the next descriptor.
- R9: `evt_desc_done` pulses for exactly one cycle after the writeback of a descriptor whose interrupt flag (status bit 12) is set. It does not pulse for any other descriptor.
- R10: If `tx_underrun` is high at any time from the acceptance of descriptor word 0 until that descriptor's writeback, the writeback sets status bit 1. The ready flag is still cleared.
- R11: A descriptor with length 0 produces no byte. It is still written back and advances the ring pointer.
- R12: Once `tx_valid` is high without `tx_ready`, `tx_valid` stays high and `tx_data` stays stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_base | input | AW | Byte address of the first descriptor (8-byte aligned) |
| cmd_clear_halt | input | 1 | One-cycle pulse that releases the halted engine |
| cmd_stop_req | input | 1 | Level; asks for a stop at the next frame boundary |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write of `mem_req_wdata`, 0 = 32-bit read |
| mem_req_addr | output | AW | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data (descriptor word 0) |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data, little-endian byte lanes |
| tx_valid | output | 1 | Byte present |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_fcs | output | 1 | MAC shall append the frame check sequence |
| tx_underrun | input | 1 | MAC reports a starved transmission |
| eng_halted | output | 1 | Engine is halted |
| evt_desc_done | output | 1 | One-cycle pulse: a descriptor with interrupt flag completed |
| evt_stop_done | output | 1 | One-cycle pulse: graceful stop reached |

## Verification
The assertions assume that memory returns exactly one read response for each accepted read, and never a response while no read is outstanding. They also assume that writes need no response, that the ring base is 8-byte aligned, and that `cmd_clear_halt` is a single-cycle pulse. The bench's memory model keeps to these rules. It holds at most one pending read, returns it after zero to two idle cycles, and toggles its acceptance signal in some runs. The MAC model throttles `tx_ready` in a fixed pattern, so that stalled bytes occur. A sweep over every start offset within a word and lengths 0 to 6 covers all lane and word-crossing cases.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int unsigned LEN_W      = 16;
  localparam int unsigned DESC_BYTES = 8;

  // status field bit positions (upper half of descriptor word 0)
  localparam int unsigned ST_READY    = 15;
  localparam int unsigned ST_WRAP     = 13;
  localparam int unsigned ST_IRQ      = 12;
  localparam int unsigned ST_LAST     = 11;
  localparam int unsigned ST_FCS      = 10;
  localparam int unsigned ST_UNDERRUN = 1;

  typedef enum logic [3:0] {
    S_HALT, S_CHECK, S_D0_REQ, S_D0_WAIT, S_D1_REQ, S_D1_WAIT,
    S_B_REQ, S_B_WAIT, S_SEND, S_WB, S_NEXT
  } txd_state_e;

  typedef enum logic [2:0] {
    RQ_NONE, RQ_DESC0, RQ_DESC1, RQ_BUF, RQ_WBACK
  } txd_req_e;

endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr
  import txd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          init_en,
  input  logic          step_en,
  input  logic          wrap_sel,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          started_q, started_d;

  always_comb begin
    ptr_d     = ptr_q;
    started_d = started_q;
    if (init_en && !started_q) begin
      ptr_d     = base;
      started_d = 1'b1;
    end else if (step_en) begin
      ptr_d = wrap_sel ? base : ptr_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      started_q <= 1'b0;
    end else begin
      if (init_en || step_en) begin
        ptr_q     <= ptr_d;
        started_q <= started_d;
      end
    end
  end

  assign ptr = ptr_q;

  // R6
  wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && wrap_sel |=> ptr_q == $past(base));

endmodule

// File: rtl/txd_buf_cursor.sv
module txd_buf_cursor
  import txd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [AW-1:0]    load_addr,
  input  logic [LEN_W-1:0] load_len,
  input  logic             word_en,
  input  logic [31:0]      word_in,
  input  logic             step_en,
  output logic [AW-1:0]    word_addr,
  output logic [7:0]       byte_out,
  output logic             last_byte,
  output logic             lane_end
);

  localparam int unsigned LANES = 4;

  logic [AW-1:0]    addr_q, addr_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [31:0]      word_q;
  logic [7:0]       lane [LANES];

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load_en) begin
      addr_d = load_addr;
      rem_d  = load_len;
    end else if (step_en) begin
      addr_d = addr_q + AW'(1);
      rem_d  = rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_en || step_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_in;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_q[8*g +: 8];
  end

  assign byte_out  = lane[addr_q[1:0]];
  assign word_addr = {addr_q[AW-1:2], 2'b00};
  assign last_byte = (rem_q == LEN_W'(1));
  assign lane_end  = (addr_q[1:0] == 2'b11);

  // R3
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> rem_q != '0);

endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_halt,
  input  logic             stop_req,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_data,
  input  logic             tx_ready,
  input  logic             tx_underrun,
  input  logic             cur_last_byte,
  input  logic             cur_lane_end,
  output txd_state_e       state,
  output txd_req_e         req_kind,
  output logic             ptr_init,
  output logic             ptr_step,
  output logic             ptr_wrap,
  output logic             cur_load,
  output logic             cur_word_en,
  output logic             cur_step,
  output logic [LEN_W-1:0] desc_len,
  output logic [15:0]      desc_stat,
  output logic [31:0]      wb_word,
  output logic             evt_done,
  output logic             evt_stop
);

  txd_state_e       st_q, st_d;
  logic [15:0]      stat_q, stat_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ur_q, ur_d;
  logic             open_q, open_d;
  logic             done_q, done_d;
  logic             sdone_q, sdone_d;
  logic [15:0]      stat_wb;
  logic             in_desc;

  assign in_desc = (st_q == S_D1_REQ) || (st_q == S_D1_WAIT) || (st_q == S_B_REQ) ||
                   (st_q == S_B_WAIT) || (st_q == S_SEND)    || (st_q == S_WB);

  always_comb begin
    st_d        = st_q;
    stat_d      = stat_q;
    len_d       = len_q;
    ur_d        = ur_q | (in_desc & tx_underrun);
    open_d      = open_q;
    done_d      = 1'b0;
    sdone_d     = 1'b0;
    req_kind    = RQ_NONE;
    ptr_init    = 1'b0;
    ptr_step    = 1'b0;
    cur_load    = 1'b0;
    cur_word_en = 1'b0;
    cur_step    = 1'b0;
    unique case (st_q)
      S_HALT: begin
        if (clear_halt) begin
          ptr_init = 1'b1;
          st_d     = S_CHECK;
        end
      end
      S_CHECK: begin
        if (stop_req && !open_q) begin
          sdone_d = 1'b1;
          st_d    = S_HALT;
        end else begin
          st_d = S_D0_REQ;
        end
      end
      S_D0_REQ: begin
        req_kind = RQ_DESC0;
        if (req_ready) st_d = S_D0_WAIT;
      end
      S_D0_WAIT: begin
        if (rsp_valid) begin
          stat_d = rsp_data[31:16];
          len_d  = rsp_data[LEN_W-1:0];
          ur_d   = 1'b0;
          st_d   = rsp_data[16+ST_READY] ? S_D1_REQ : S_HALT;
        end
      end
      S_D1_REQ: begin
        req_kind = RQ_DESC1;
        if (req_ready) st_d = S_D1_WAIT;
      end
      S_D1_WAIT: begin
        if (rsp_valid) begin
          cur_load = 1'b1;
          st_d     = (len_q == '0) ? S_WB : S_B_REQ;
        end
      end
      S_B_REQ: begin
        req_kind = RQ_BUF;
        if (req_ready) st_d = S_B_WAIT;
      end
      S_B_WAIT: begin
        if (rsp_valid) begin
          cur_word_en = 1'b1;
          st_d        = S_SEND;
        end
      end
      S_SEND: begin
        if (tx_ready) begin
          cur_step = 1'b1;
          if (cur_last_byte)     st_d = S_WB;
          else if (cur_lane_end) st_d = S_B_REQ;
        end
      end
      S_WB: begin
        req_kind = RQ_WBACK;
        if (req_ready) begin
          done_d = stat_q[ST_IRQ];
          open_d = !stat_q[ST_LAST];
          st_d   = S_NEXT;
        end
      end
      S_NEXT: begin
        ptr_step = 1'b1;
        st_d     = S_CHECK;
      end
      default: st_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_HALT;
      stat_q  <= '0;
      len_q   <= '0;
      ur_q    <= 1'b0;
      open_q  <= 1'b0;
      done_q  <= 1'b0;
      sdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stat_q  <= stat_d;
      len_q   <= len_d;
      ur_q    <= ur_d;
      open_q  <= open_d;
      done_q  <= done_d;
      sdone_q <= sdone_d;
    end
  end

  always_comb begin
    stat_wb              = stat_q;
    stat_wb[ST_READY]    = 1'b0;
    stat_wb[ST_UNDERRUN] = stat_q[ST_UNDERRUN] | ur_q | tx_underrun;
  end

  assign state     = st_q;
  assign ptr_wrap  = stat_q[ST_WRAP];
  assign desc_len  = len_q;
  assign desc_stat = stat_q;
  assign wb_word   = {stat_wb, len_q};
  assign evt_done  = done_q;
  assign evt_stop  = sdone_q;

  // R2
  unowned_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_D0_WAIT) && rsp_valid && !rsp_data[16+ST_READY] |=> st_q == S_HALT);

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SEND) && tx_underrun |=> ur_q);

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
  import txd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_ring_base,
  input  logic          cmd_clear_halt,
  input  logic          cmd_stop_req,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_fcs,
  input  logic          tx_underrun,
  output logic          eng_halted,
  output logic          evt_desc_done,
  output logic          evt_stop_done
);

  localparam logic [AW-1:0] WORD1_OFS = AW'(4);

  txd_state_e       state;
  txd_req_e         req_kind;
  logic             ptr_init, ptr_step, ptr_wrap;
  logic             cur_load, cur_word_en, cur_step;
  logic [LEN_W-1:0] desc_len;
  logic [15:0]      desc_stat;
  logic [31:0]      wb_word;
  logic [AW-1:0]    ring_ptr, buf_word_addr;
  logic [7:0]       cur_byte;
  logic             cur_last_byte, cur_lane_end;

  txd_ctrl i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_halt    (cmd_clear_halt),
    .stop_req      (cmd_stop_req),
    .req_ready     (mem_req_ready),
    .rsp_valid     (mem_rsp_valid),
    .rsp_data      (mem_rsp_data),
    .tx_ready      (tx_ready),
    .tx_underrun   (tx_underrun),
    .cur_last_byte (cur_last_byte),
    .cur_lane_end  (cur_lane_end),
    .state         (state),
    .req_kind      (req_kind),
    .ptr_init      (ptr_init),
    .ptr_step      (ptr_step),
    .ptr_wrap      (ptr_wrap),
    .cur_load      (cur_load),
    .cur_word_en   (cur_word_en),
    .cur_step      (cur_step),
    .desc_len      (desc_len),
    .desc_stat     (desc_stat),
    .wb_word       (wb_word),
    .evt_done      (evt_desc_done),
    .evt_stop      (evt_stop_done)
  );

  txd_ring_ptr #(.AW(AW)) i_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (cfg_ring_base),
    .init_en  (ptr_init),
    .step_en  (ptr_step),
    .wrap_sel (ptr_wrap),
    .ptr      (ring_ptr)
  );

  txd_buf_cursor #(.AW(AW)) i_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (cur_load),
    .load_addr (mem_rsp_data[AW-1:0]),
    .load_len  (desc_len),
    .word_en   (cur_word_en),
    .word_in   (mem_rsp_data),
    .step_en   (cur_step),
    .word_addr (buf_word_addr),
    .byte_out  (cur_byte),
    .last_byte (cur_last_byte),
    .lane_end  (cur_lane_end)
  );

  always_comb begin
    unique case (req_kind)
      RQ_DESC1: mem_req_addr = ring_ptr + WORD1_OFS;
      RQ_BUF:   mem_req_addr = buf_word_addr;
      default:  mem_req_addr = ring_ptr;
    endcase
  end

  assign mem_req_valid = (req_kind != RQ_NONE);
  assign mem_req_write = (req_kind == RQ_WBACK);
  assign mem_req_wdata = wb_word;

  assign tx_valid   = (state == S_SEND);
  assign tx_data    = cur_byte;
  assign tx_last    = tx_valid & cur_last_byte & desc_stat[ST_LAST];
  assign tx_fcs     = tx_valid & desc_stat[ST_FCS];
  assign eng_halted = (state == S_HALT);

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_halted |-> !mem_req_valid && !tx_valid);

  // R5
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> !mem_req_wdata[16+ST_READY]);

  // R8
  stop_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop_done |-> eng_halted);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_desc_done |=> !evt_desc_done);

endmodule

// File: tb/test_txd_ring_engine.sv
module test_txd_ring_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [15:0] F_RDY = 16'h8000, F_WRAP = 16'h2000, F_IRQ = 16'h1000,
                          F_LAST = 16'h0800, F_FCS = 16'h0400, F_UR = 16'h0002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfg_ring_base = '0;
  logic cmd_clear_halt = 1'b0, cmd_stop_req = 1'b0, tx_underrun = 1'b0;
  logic mem_req_valid, mem_req_write, mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_data;
  logic tx_valid, tx_ready, tx_last, tx_fcs;
  logic [7:0] tx_data;
  logic eng_halted, evt_desc_done, evt_stop_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_ring_engine #(.AW(AW)) i_txd_ring_engine (.*);

  logic [31:0] mem [0:63];
  int cyc = 0, n = 0, rd_n = 0, wr_n = 0, done_n = 0, sdone_n = 0, hold_bad = 0;
  logic [7:0] got_d [0:1023];
  logic got_l [0:1023];
  logic got_f [0:1023];
  logic [31:0] rd_log [0:4095];
  bit pend = 0; int lat = 0; logic [31:0] pend_d = '0;
  bit stall_mode = 0, slow_mac = 0;
  bit prev_hold = 0; logic [7:0] prev_byte = '0;
  int checks = 0, fails = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; tx_ready = 1'b0;
    end else begin
      if (prev_hold && !(tx_valid && tx_data == prev_byte)) hold_bad++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pend_d; pend = 0; end
        else lat--;
      end
      mem_req_ready = stall_mode ? (cyc % 2 == 0) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin mem[mem_req_addr[7:2]] = mem_req_wdata; wr_n++; end
        else begin
          pend = 1; pend_d = mem[mem_req_addr[7:2]]; lat = cyc % 3;
          rd_log[rd_n % 4096] = mem_req_addr; rd_n++;
        end
      end
      tx_ready = slow_mac ? (cyc % 3 != 1) : 1'b1;
      prev_hold = tx_valid && !tx_ready;
      prev_byte = tx_data;
      if (tx_valid && tx_ready) begin
        got_d[n % 1024] = tx_data; got_l[n % 1024] = tx_last; got_f[n % 1024] = tx_fcs; n++;
      end
      if (evt_desc_done) done_n++;
      if (evt_stop_done) sdone_n++;
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int w = 0; w < 64; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
  endtask

  task automatic put_desc(int a, logic [15:0] st, logic [15:0] len, logic [31:0] bp);
    mem[a >> 2] = {st, len};
    mem[(a >> 2) + 1] = bp;
  endtask

  task automatic kick();
    @(negedge clk); cmd_clear_halt = 1'b1;
    @(negedge clk); cmd_clear_halt = 1'b0;
  endtask

  task automatic wait_halt();
    int t = 0;
    while (!eng_halted && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) chk(0, "watchdog", t, 0);
    repeat (3) @(negedge clk);
  endtask

  // expected bytes of buffer at bp, length len, starting at stream index s
  task automatic chk_bytes(int s, int bp, int len, bit lastf, bit fcsf, string req);
    bit ok_d = 1, ok_l = 1, ok_f = 1;
    for (int i = 0; i < len; i++) begin
      if (got_d[(s+i) % 1024] !== pat(bp + i)) ok_d = 0;
      if (got_l[(s+i) % 1024] !== (lastf && i == len - 1)) ok_l = 0;
      if (got_f[(s+i) % 1024] !== fcsf) ok_f = 0;
    end
    chk(ok_d, {req, " R3 data"}, ok_d, 1);
    chk(ok_l, {req, " R4 last"}, ok_l, 1);
    chk(ok_f, {req, " R4 fcs"}, ok_f, 1);
  endtask

  initial begin
    int s, r, d0, bp;
    logic [15:0] st;
    fill_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(eng_halted === 1'b1, "R1 halted", eng_halted, 1);
    chk(tx_valid === 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep: single wrapping descriptor, every lane offset, lengths 0..6
    for (int off = 0; off < 4; off++) begin
      for (int len = 0; len <= 6; len++) begin
        stall_mode = off[0]; slow_mac = len[0];
        bp = 8'h40 + 16 * off + off;
        st = F_RDY | F_WRAP | F_LAST | F_FCS | ((len % 2) ? F_IRQ : 16'h0);
        put_desc(0, st, 16'(len), bp);
        s = n; r = rd_n; d0 = done_n;
        kick(); wait_halt();
        if (off == 0 && len == 0) chk(rd_log[r] == 0, "R1 first fetch at base", rd_log[r], 0);
        chk(rd_log[(r+1) % 4096] == 4, "R2 word1 address", rd_log[(r+1) % 4096], 4);
        chk(n - s == len, len == 0 ? "R11 byte count" : "R3 byte count", n - s, len);
        chk_bytes(s, bp, len, 1, 1, "sweep");
        chk(mem[0] == {st & ~F_RDY, 16'(len)}, "R5 writeback", mem[0], {st & ~F_RDY, 16'(len)});
        chk(done_n - d0 == len % 2, "R9 done events", done_n - d0, len % 2);
        chk(rd_log[(rd_n-1) % 4096] == 0, "R6 wrap refetch at base", rd_log[(rd_n-1) % 4096], 0);
        chk(eng_halted, "R2 halt on unowned", eng_halted, 1);
      end
    end

    // Three-descriptor ring, multi-buffer frame
    stall_mode = 1; slow_mac = 1;
    put_desc(0,  F_RDY | F_FCS, 3, 8'h41);
    put_desc(8,  F_RDY | F_LAST | F_IRQ | F_FCS, 5, 8'h62);
    put_desc(16, F_RDY | F_LAST | F_WRAP, 2, 8'h87);
    s = n; d0 = done_n; r = wr_n;
    kick(); wait_halt();
    chk(n - s == 10, "R3 ring byte count", n - s, 10);
    chk_bytes(s, 8'h41, 3, 0, 1, "ring d0");
    chk_bytes(s + 3, 8'h62, 5, 1, 1, "ring d1");
    chk_bytes(s + 8, 8'h87, 2, 1, 0, "ring d2");
    chk(done_n - d0 == 1, "R9 ring done", done_n - d0, 1);
    chk(wr_n - r == 3, "R5 ring writebacks", wr_n - r, 3);
    chk(rd_log[(rd_n-1) % 4096] == 0, "R6 wrap to base", rd_log[(rd_n-1) % 4096], 0);

    // Halt on unowned descriptor, then resume at the same one
    put_desc(0, F_RDY | F_LAST, 2, 8'hA0);
    put_desc(8, F_LAST, 1, 8'hB3);
    s = n;
    kick(); wait_halt();
    chk(rd_log[(rd_n-1) % 4096] == 8, "R7 halted at second", rd_log[(rd_n-1) % 4096], 8);
    r = rd_n;
    repeat (20) @(negedge clk);
    chk(rd_n == r, "R7 no fetch while halted", rd_n, r);
    put_desc(8, F_RDY | F_LAST | F_WRAP, 1, 8'hB3);
    kick(); wait_halt();
    chk(rd_log[r % 4096] == 8, "R7 resume same descriptor", rd_log[r % 4096], 8);
    chk(n - s == 3 && got_d[(s+2) % 1024] == pat(8'hB3), "R7 resumed byte", got_d[(s+2) % 1024], pat(8'hB3));

    // Graceful stop in the middle of a two-buffer frame
    put_desc(0,  F_RDY, 6, 8'h50);
    put_desc(8,  F_RDY | F_LAST, 4, 8'h70);
    put_desc(16, F_RDY | F_LAST | F_WRAP, 3, 8'h90);
    s = n; d0 = sdone_n;
    kick();
    while (n == s) @(negedge clk);
    cmd_stop_req = 1'b1;
    wait_halt();
    chk(n - s == 10, "R8 frame finished", n - s, 10);
    chk(sdone_n - d0 == 1, "R8 stop event", sdone_n - d0, 1);
    chk(mem[4][31] == 1'b1, "R8 next descriptor untouched", mem[4][31], 1);
    chk(mem[2][31] == 1'b0, "R8 frame end released", mem[2][31], 0);
    cmd_stop_req = 1'b0;
    kick(); wait_halt();
    chk(n - s == 13, "R8 resume after stop", n - s, 13);
    chk(sdone_n - d0 == 1, "R8 no extra stop event", sdone_n - d0, 1);

    // Underrun during a descriptor
    put_desc(0, F_RDY | F_LAST | F_WRAP, 4, 8'hC1);
    s = n;
    kick();
    while (n == s) @(negedge clk);
    tx_underrun = 1'b1; @(negedge clk); tx_underrun = 1'b0;
    wait_halt();
    chk(mem[0] == {(F_LAST | F_WRAP | F_UR), 16'd4}, "R10 underrun writeback",
        mem[0], {(F_LAST | F_WRAP | F_UR), 16'd4});

    chk(hold_bad == 0, "R12 byte held while stalled", hold_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule